// File: doc/BRIEF.md
# Ethernet Transmit Error Status Controller

This block sits beside one Ethernet transmit channel and turns abnormal transmit events into per-frame status flags. It also keeps a sticky transmit-error event and holds the channel in a halted state after fatal faults. The MAC datapath, backoff timing, CRC generation and descriptor memory are outside the block. They appear only as strobes in and requests out: frame start and frame end, an underrun flag, a late-collision flag, a retry-limit flag, the receive-enable and collision pins, and a restart command.

Fatal faults end the frame at once. These are an underrun, an exhausted retry count and a late collision. The block closes and aborts the buffer and then refuses new frames until a restart command arrives. An underrun first asks the datapath to append 32 bits that corrupt the CRC, carried over `JAM_CYCLES` nibble-clock cycles. Non-fatal conditions only set a flag while the frame runs to its end. These are a loss of carrier with no collision in the frame, and a missing heartbeat after the frame. When heartbeat checking is on, the buffer close waits until a collision shows up inside a window of `HB_WINDOW` clocks after the frame end, or until that window runs out.

Top module: `tx_fault_monitor`

## Requirements
- R1: An underrun sampled during a frame drives `force_bad_crc` high for exactly `JAM_CYCLES` cycles, starting the cycle after. In the cycle that follows, `buf_close` and `abort` pulse for one cycle with `stat_un` set.
- R2: After a close caused by an underrun, a retry-limit error or a late collision, `halted` is high from the close cycle onward. While halted, `frm_start` is ignored. `halted` drops the cycle after `restart_cmd` is sampled.
- R3: Carrier sense is `rx_en | col`. If carrier sense was high during a frame and later falls while the frame is active, and no collision was seen in that frame, the frame's close shows `stat_csl`. The frame is not aborted and the channel is not halted.
- R4: A collision seen at any point while a frame is active suppresses `stat_csl` for that frame.
- R5: A retry-limit flag sampled during a frame gives `buf_close`, `abort`, `stat_rl` and `halted` in the next cycle.
- R6: A late-collision flag sampled during a frame gives `buf_close`, `abort`, `stat_lc` and `halted` in the next cycle.
- R7: With `hb_chk_en` high at frame end, if no collision is seen in the `HB_WINDOW` cycles after the end strobe, `buf_close` pulses with `stat_hb` in the cycle after the last window cycle. There is no abort and no halt.
- R8: A collision inside the heartbeat window closes the buffer in the next cycle, with no status bit set and no event raised.
- R9: With `hb_chk_en` low, `frm_end` closes the buffer in the next cycle.
- R10: Status bits take their values in the `buf_close` cycle and hold them until the cycle after an accepted `frm_start`, when they clear.
- R11: `tx_err_evt` sets when a close carries any status bit. It stays set until `evt_clr` is sampled, and a set in the same cycle wins over the clear.
- R12: `tx_err_irq` equals `tx_err_evt & evt_mask`.
- R13: `restart_cmd` while not halted has no effect on any output.
- R14: When several faults are sampled in the same cycle, the priority is underrun first, then late collision, then retry limit, then frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Frame start strobe |
| frm_end | input | 1 | Frame end strobe |
| underrun | input | 1 | Transmit FIFO underrun |
| rx_en | input | 1 | Receive-enable pin from the transceiver |
| col | input | 1 | Collision pin from the transceiver |
| late_col | input | 1 | Late collision flag from the MAC |
| retry_lim | input | 1 | Retry limit reached flag |
| hb_chk_en | input | 1 | Enable heartbeat checking |
| restart_cmd | input | 1 | Restart-transmit command |
| evt_clr | input | 1 | Write-one-to-clear for the error event |
| evt_mask | input | 1 | Interrupt mask for the error event |
| force_bad_crc | output | 1 | Request to append CRC-corrupting bits |
| buf_close | output | 1 | Buffer close strobe |
| abort | output | 1 | Frame abort strobe |
| stat_un | output | 1 | Underrun status |
| stat_csl | output | 1 | Carrier-lost status |
| stat_rl | output | 1 | Retry-limit status |
| stat_lc | output | 1 | Late-collision status |
| stat_hb | output | 1 | Heartbeat-missing status |
| tx_err_evt | output | 1 | Sticky transmit-error event |
| tx_err_irq | output | 1 | Masked transmit-error interrupt |
| halted | output | 1 | Channel halted awaiting restart |

## Verification
The bench checks the heartbeat window edge. If the window is off by one, the close moves a cycle early or late, or a collision in the last window cycle wrongly raises `stat_hb`. The bench also measures the jam length and runs frames where carrier drops after a collision. A design that forgets the collision history would flag carrier loss there. Simultaneous faults check the priority order, and a wrong order shows up as the wrong status bit or a missing CRC-corruption request. A frame start sent while halted, and a restart sent while idle, catch designs that clear status or leave the halt state when they should not.

// File: rtl/txe_pkg.sv
package txe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEND   = 3'd1,
    ST_JAM    = 3'd2,
    ST_HBWAIT = 3'd3,
    ST_HALT   = 3'd4
  } txe_state_e;

  typedef struct packed {
    logic un;
    logic csl;
    logic rl;
    logic lc;
    logic hb;
  } txe_flags_t;

  localparam txe_flags_t FLAGS_NONE = '{un: 1'b0, csl: 1'b0, rl: 1'b0, lc: 1'b0, hb: 1'b0};

endpackage

// File: rtl/txe_rst_sync.sv
module txe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/txe_carrier.sv
module txe_carrier (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clr,
  input  logic frame_live,
  input  logic rx_en,
  input  logic col,
  output logic csl_now
);

  logic cs_up_q, drop_q, colf_q;
  logic cs_up_d, drop_d, colf_d;
  logic carrier, drop_now, col_now, upd_en;

  always_comb begin
    carrier  = rx_en | col;
    drop_now = drop_q | (frame_live & cs_up_q & ~carrier);
    col_now  = colf_q | (frame_live & col);
    csl_now  = drop_now & ~col_now;
    upd_en   = frame_clr | frame_live;
    if (frame_clr) begin
      cs_up_d = 1'b0;
      drop_d  = 1'b0;
      colf_d  = 1'b0;
    end else begin
      cs_up_d = cs_up_q | carrier;
      drop_d  = drop_now;
      colf_d  = col_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_up_q <= 1'b0;
      drop_q  <= 1'b0;
      colf_q  <= 1'b0;
    end else if (upd_en) begin
      cs_up_q <= cs_up_d;
      drop_q  <= drop_d;
      colf_q  <= colf_d;
    end
  end

endmodule

// File: rtl/txe_seq.sv
module txe_seq
  import txe_pkg::*;
#(
  parameter int JAM_CYCLES = 8,
  parameter int HB_WINDOW  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_start,
  input  logic       frm_end,
  input  logic       underrun,
  input  logic       late_col,
  input  logic       retry_lim,
  input  logic       hb_chk_en,
  input  logic       col,
  input  logic       restart_cmd,
  input  logic       csl_now,
  output txe_state_e state_o,
  output logic       frame_accept,
  output logic       close_fire,
  output logic       abort_fire,
  output txe_flags_t close_flags
);

  localparam int CNT_MAX = (JAM_CYCLES > HB_WINDOW) ? JAM_CYCLES : HB_WINDOW;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] JAM_LAST = CNT_W'(JAM_CYCLES - 1);
  localparam logic [CNT_W-1:0] HB_LAST  = CNT_W'(HB_WINDOW - 1);

  txe_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cslp_q, cslp_d;
  logic             cnt_en;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    cslp_d       = cslp_q;
    cnt_en       = 1'b0;
    frame_accept = 1'b0;
    close_fire   = 1'b0;
    abort_fire   = 1'b0;
    close_flags  = FLAGS_NONE;
    unique case (state_q)
      ST_IDLE: begin
        if (frm_start) begin
          frame_accept = 1'b1;
          state_d      = ST_SEND;
        end
      end
      ST_SEND: begin
        if (underrun) begin
          cslp_d  = csl_now;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          state_d = ST_JAM;
        end else if (late_col) begin
          close_fire      = 1'b1;
          abort_fire      = 1'b1;
          close_flags.lc  = 1'b1;
          close_flags.csl = csl_now;
          state_d         = ST_HALT;
        end else if (retry_lim) begin
          close_fire      = 1'b1;
          abort_fire      = 1'b1;
          close_flags.rl  = 1'b1;
          close_flags.csl = csl_now;
          state_d         = ST_HALT;
        end else if (frm_end) begin
          if (hb_chk_en) begin
            cslp_d  = csl_now;
            cnt_d   = '0;
            cnt_en  = 1'b1;
            state_d = ST_HBWAIT;
          end else begin
            close_fire      = 1'b1;
            close_flags.csl = csl_now;
            state_d         = ST_IDLE;
          end
        end
      end
      ST_JAM: begin
        if (cnt_q == JAM_LAST) begin
          close_fire      = 1'b1;
          abort_fire      = 1'b1;
          close_flags.un  = 1'b1;
          close_flags.csl = cslp_q;
          state_d         = ST_HALT;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_HBWAIT: begin
        if (col) begin
          close_fire      = 1'b1;
          close_flags.csl = cslp_q;
          state_d         = ST_IDLE;
        end else if (cnt_q == HB_LAST) begin
          close_fire      = 1'b1;
          close_flags.hb  = 1'b1;
          close_flags.csl = cslp_q;
          state_d         = ST_IDLE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_HALT: begin
        if (restart_cmd) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cslp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cslp_q  <= cslp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/txe_status.sv
module txe_status
  import txe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_accept,
  input  logic       close_fire,
  input  logic       abort_fire,
  input  txe_flags_t close_flags,
  input  logic       evt_clr,
  input  logic       evt_mask,
  output logic       buf_close,
  output logic       abort,
  output txe_flags_t flags,
  output logic       evt,
  output logic       irq
);

  txe_flags_t flags_q, flags_d;
  logic       close_q, abort_q, evt_q, evt_d, flags_en;

  always_comb begin
    flags_en = close_fire | frame_accept;
    flags_d  = close_fire ? close_flags : FLAGS_NONE;
    if (close_fire && (|close_flags)) evt_d = 1'b1;
    else if (evt_clr)                 evt_d = 1'b0;
    else                              evt_d = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      close_q <= 1'b0;
      abort_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      close_q <= close_fire;
      abort_q <= abort_fire;
      evt_q   <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= FLAGS_NONE;
    else if (flags_en) flags_q <= flags_d;
  end

  assign buf_close = close_q;
  assign abort     = abort_q;
  assign flags     = flags_q;
  assign evt       = evt_q;
  assign irq       = evt_q & evt_mask;

endmodule

// File: rtl/tx_fault_monitor.sv
module tx_fault_monitor
  import txe_pkg::*;
#(
  parameter int JAM_CYCLES = 8,
  parameter int HB_WINDOW  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic frm_end,
  input  logic underrun,
  input  logic rx_en,
  input  logic col,
  input  logic late_col,
  input  logic retry_lim,
  input  logic hb_chk_en,
  input  logic restart_cmd,
  input  logic evt_clr,
  input  logic evt_mask,
  output logic force_bad_crc,
  output logic buf_close,
  output logic abort,
  output logic stat_un,
  output logic stat_csl,
  output logic stat_rl,
  output logic stat_lc,
  output logic stat_hb,
  output logic tx_err_evt,
  output logic tx_err_irq,
  output logic halted
);

  logic       rst_n_i;
  txe_state_e state;
  logic       frame_accept, close_fire, abort_fire, csl_now;
  txe_flags_t close_flags, flags;

  txe_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  txe_carrier u_car (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .frame_clr  (frame_accept),
    .frame_live (state == ST_SEND),
    .rx_en      (rx_en),
    .col        (col),
    .csl_now    (csl_now)
  );

  txe_seq #(.JAM_CYCLES(JAM_CYCLES), .HB_WINDOW(HB_WINDOW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .frm_start    (frm_start),
    .frm_end      (frm_end),
    .underrun     (underrun),
    .late_col     (late_col),
    .retry_lim    (retry_lim),
    .hb_chk_en    (hb_chk_en),
    .col          (col),
    .restart_cmd  (restart_cmd),
    .csl_now      (csl_now),
    .state_o      (state),
    .frame_accept (frame_accept),
    .close_fire   (close_fire),
    .abort_fire   (abort_fire),
    .close_flags  (close_flags)
  );

  txe_status u_stat (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .frame_accept (frame_accept),
    .close_fire   (close_fire),
    .abort_fire   (abort_fire),
    .close_flags  (close_flags),
    .evt_clr      (evt_clr),
    .evt_mask     (evt_mask),
    .buf_close    (buf_close),
    .abort        (abort),
    .flags        (flags),
    .evt          (tx_err_evt),
    .irq          (tx_err_irq)
  );

  assign force_bad_crc = (state == ST_JAM);
  assign halted        = (state == ST_HALT);
  assign stat_un       = flags.un;
  assign stat_csl      = flags.csl;
  assign stat_rl       = flags.rl;
  assign stat_lc       = flags.lc;
  assign stat_hb       = flags.hb;

endmodule

// File: rtl/tx_fault_monitor_chk.sv
module tx_fault_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic restart_cmd,
  input logic evt_clr,
  input logic force_bad_crc,
  input logic buf_close,
  input logic abort,
  input logic stat_un,
  input logic stat_rl,
  input logic stat_lc,
  input logic stat_hb,
  input logic tx_err_evt,
  input logic halted
);

  a_r1_jam_ends_in_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_bad_crc) |-> (buf_close && abort && stat_un));

  a_r1_no_close_in_jam: assert property (@(posedge clk) disable iff (!rst_n)
    force_bad_crc |-> (!buf_close && !halted));

  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart_cmd) |=> halted);

  a_r5_rl_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_close && stat_rl) |-> (halted && abort));

  a_r6_lc_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_close && stat_lc) |-> (halted && abort));

  a_r7_hb_is_soft: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_close && stat_hb) |-> (!abort && !halted));

  a_r11_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err_evt && !evt_clr) |=> tx_err_evt);

endmodule

bind tx_fault_monitor tx_fault_monitor_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .restart_cmd   (restart_cmd),
  .evt_clr       (evt_clr),
  .force_bad_crc (force_bad_crc),
  .buf_close     (buf_close),
  .abort         (abort),
  .stat_un       (stat_un),
  .stat_rl       (stat_rl),
  .stat_lc       (stat_lc),
  .stat_hb       (stat_hb),
  .tx_err_evt    (tx_err_evt),
  .halted        (halted)
);

// File: tb/tb_tx_fault_monitor.sv
`timescale 1ns/1ps
module tb_tx_fault_monitor;

  localparam int JAM = 8;
  localparam int HBW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic frm_start = 0, frm_end = 0, underrun = 0, rx_en = 0, col = 0;
  logic late_col = 0, retry_lim = 0, hb_chk_en = 0, restart_cmd = 0;
  logic evt_clr = 0, evt_mask = 0;
  logic force_bad_crc, buf_close, abort, stat_un, stat_csl, stat_rl, stat_lc, stat_hb;
  logic tx_err_evt, tx_err_irq, halted;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  tx_fault_monitor #(.JAM_CYCLES(JAM), .HB_WINDOW(HBW)) dut (.*);

  // behavioural reference model
  int   m_st = 0;   // 0 idle 1 send 2 jam 3 hb-wait 4 halt
  int   m_cnt = 0, m_rcnt = 0;
  bit   m_csup = 0, m_drop = 0, m_colf = 0, m_cslp = 0;
  bit   m_close = 0, m_abort = 0, m_evt = 0;
  bit   m_un = 0, m_csl = 0, m_rl = 0, m_lc = 0, m_hb = 0;

  task automatic m_reset();
    m_st = 0; m_cnt = 0; m_csup = 0; m_drop = 0; m_colf = 0; m_cslp = 0;
    m_close = 0; m_abort = 0; m_evt = 0;
    m_un = 0; m_csl = 0; m_rl = 0; m_lc = 0; m_hb = 0;
  endtask

  task automatic m_finish(bit ab, bit un, bit cs, bit rl, bit lc, bit hb);
    m_close = 1; m_abort = ab;
    m_un = un; m_csl = cs; m_rl = rl; m_lc = lc; m_hb = hb;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rcnt = 0;
      m_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      bit car, dn, cn, cs, clr_seen;
      car = rx_en | col;
      m_close = 0; m_abort = 0;
      clr_seen = evt_clr;
      case (m_st)
        0: if (frm_start) begin
             m_st = 1; m_csup = 0; m_drop = 0; m_colf = 0;
             m_un = 0; m_csl = 0; m_rl = 0; m_lc = 0; m_hb = 0;
           end
        1: begin
             dn = m_drop | (m_csup & !car);
             cn = m_colf | col;
             cs = dn & !cn;
             if (underrun) begin m_cslp = cs; m_st = 2; m_cnt = 0; end
             else if (late_col) begin m_finish(1, 0, cs, 0, 1, 0); m_st = 4; end
             else if (retry_lim) begin m_finish(1, 0, cs, 1, 0, 0); m_st = 4; end
             else if (frm_end) begin
               if (hb_chk_en) begin m_cslp = cs; m_st = 3; m_cnt = 0; end
               else begin m_finish(0, 0, cs, 0, 0, 0); m_st = 0; end
             end else begin
               m_csup = m_csup | car; m_drop = dn; m_colf = cn;
             end
           end
        2: if (m_cnt == JAM - 1) begin m_finish(1, 1, m_cslp, 0, 0, 0); m_st = 4; end
           else m_cnt++;
        3: if (col) begin m_finish(0, 0, m_cslp, 0, 0, 0); m_st = 0; end
           else if (m_cnt == HBW - 1) begin m_finish(0, 0, m_cslp, 0, 0, 1); m_st = 0; end
           else m_cnt++;
        default: if (restart_cmd) m_st = 0;
      endcase
      if (m_close && (m_un | m_csl | m_rl | m_lc | m_hb)) m_evt = 1;
      else if (clr_seen) m_evt = 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 force_bad_crc vs model", force_bad_crc, m_st == 2);
      chk("R2 halted vs model", halted, m_st == 4);
      chk("R9 buf_close vs model", buf_close, m_close);
      chk("R6 abort vs model", abort, m_abort);
      chk("R1 stat_un vs model", stat_un, m_un);
      chk("R3 stat_csl vs model", stat_csl, m_csl);
      chk("R5 stat_rl vs model", stat_rl, m_rl);
      chk("R6 stat_lc vs model", stat_lc, m_lc);
      chk("R7 stat_hb vs model", stat_hb, m_hb);
      chk("R11 tx_err_evt vs model", tx_err_evt, m_evt);
      chk("R12 tx_err_irq vs model", tx_err_irq, m_evt & evt_mask);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual hung expected done");
    summary();
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic frame_begin();
    frm_start = 1; rx_en = 1;
    step();
    frm_start = 0;
  endtask

  task automatic do_restart();
    restart_cmd = 1; step(); restart_cmd = 0;
  endtask

  initial begin
    #2 rst_n = 0;
    #1 cmp_on = 1;
    repeat (3) step();
    #2;
    chk("R2 reset halted", halted, 0);
    chk("R11 reset event", tx_err_evt, 0);
    chk("R10 reset status", stat_un | stat_csl | stat_rl | stat_lc | stat_hb, 0);
    rst_n = 1;
    repeat (5) step();

    // R9 plain frame, heartbeat check off
    frame_begin(); repeat (3) step();
    frm_end = 1; step(); frm_end = 0; #2;
    chk("R9 close after end", buf_close, 1);
    chk("R9 no event", tx_err_evt, 0);
    rx_en = 0; step(); #2;
    chk("R9 close is one pulse", buf_close, 0);

    // R3 carrier lost without collision
    frame_begin(); step(); rx_en = 0; step(); step();
    frm_end = 1; step(); frm_end = 0; #2;
    chk("R3 csl set", stat_csl, 1);
    chk("R3 no abort", abort, 0);
    chk("R3 not halted", halted, 0);
    chk("R11 event set", tx_err_evt, 1);
    chk("R12 masked irq", tx_err_irq, 0);
    evt_mask = 1; #1;
    chk("R12 unmasked irq", tx_err_irq, 1);
    evt_clr = 1; step(); evt_clr = 0; #2;
    chk("R11 cleared", tx_err_evt, 0);
    chk("R10 status held", stat_csl, 1);

    // R4 carrier lost after a collision
    frame_begin(); #2;
    chk("R10 cleared on start", stat_csl, 0);
    step(); col = 1; step(); col = 0; rx_en = 0; step(); step();
    frm_end = 1; step(); frm_end = 0; #2;
    chk("R4 close", buf_close, 1);
    chk("R4 no csl", stat_csl, 0);

    // R1 underrun
    frame_begin(); step();
    underrun = 1; step(); underrun = 0; #2;
    chk("R1 jam starts", force_bad_crc, 1);
    for (int i = 1; i < JAM; i++) begin
      step(); #2;
      chk("R1 jam held", force_bad_crc, 1);
      chk("R1 no early close", buf_close, 0);
    end
    step(); #2;
    chk("R1 jam ends", force_bad_crc, 0);
    chk("R1 close", buf_close, 1);
    chk("R1 abort", abort, 1);
    chk("R1 un set", stat_un, 1);
    chk("R2 halted", halted, 1);

    // R2 start ignored while halted
    frm_start = 1; step(); frm_start = 0; #2;
    chk("R2 still halted", halted, 1);
    chk("R2 status kept", stat_un, 1);
    repeat (3) step(); #2;
    chk("R2 halt holds", halted, 1);
    do_restart(); #2;
    chk("R2 released", halted, 0);

    // R13 restart while idle
    do_restart(); #2;
    chk("R13 halted unchanged", halted, 0);
    chk("R13 status unchanged", stat_un, 1);
    chk("R13 no close", buf_close, 0);
    chk("R13 event unchanged", tx_err_evt, 1);
    evt_clr = 1; step(); evt_clr = 0;

    // R5 retry limit
    frame_begin(); step();
    retry_lim = 1; step(); retry_lim = 0; #2;
    chk("R5 close", buf_close, 1);
    chk("R5 abort", abort, 1);
    chk("R5 rl", stat_rl, 1);
    chk("R5 halted", halted, 1);
    do_restart();

    // R6 late collision with clear in same cycle (R11 set wins)
    frame_begin(); step();
    late_col = 1; evt_clr = 1; step(); late_col = 0; evt_clr = 0; #2;
    chk("R6 lc", stat_lc, 1);
    chk("R6 abort", abort, 1);
    chk("R6 halted", halted, 1);
    chk("R11 set wins", tx_err_evt, 1);
    do_restart();

    // R14 priorities
    frame_begin(); step();
    underrun = 1; late_col = 1; retry_lim = 1; step();
    underrun = 0; late_col = 0; retry_lim = 0; #2;
    chk("R14 underrun first", force_bad_crc, 1);
    chk("R14 no immediate close", buf_close, 0);
    repeat (JAM) step();
    do_restart();
    frame_begin(); step();
    late_col = 1; retry_lim = 1; step(); late_col = 0; retry_lim = 0; #2;
    chk("R14 lc over rl", stat_lc, 1);
    chk("R14 rl masked", stat_rl, 0);
    do_restart();

    // R7 heartbeat missing
    evt_clr = 1; step(); evt_clr = 0;
    hb_chk_en = 1;
    frame_begin(); step();
    frm_end = 1; step(); frm_end = 0;
    for (int i = 1; i < HBW; i++) begin
      step(); #2;
      chk("R7 waiting", buf_close, 0);
    end
    step(); #2;
    chk("R7 close at window end", buf_close, 1);
    chk("R7 hb", stat_hb, 1);
    chk("R7 no abort", abort, 0);
    chk("R7 no halt", halted, 0);
    chk("R11 hb event", tx_err_evt, 1);

    // R8 heartbeat present
    evt_clr = 1; step(); evt_clr = 0;
    frame_begin(); step();
    frm_end = 1; step(); frm_end = 0;
    repeat (5) step();
    col = 1; step(); col = 0; #2;
    chk("R8 close", buf_close, 1);
    chk("R8 no hb", stat_hb, 0);
    chk("R8 no event", tx_err_evt, 0);

    // R8 collision on last window cycle
    frame_begin(); step();
    frm_end = 1; step(); frm_end = 0;
    repeat (HBW - 1) step();
    col = 1; step(); col = 0; #2;
    chk("R8 last-cycle close", buf_close, 1);
    chk("R8 last-cycle no hb", stat_hb, 0);
    hb_chk_en = 0; rx_en = 0;
    repeat (4) step();
    summary();
  end

endmodule